// File: doc/BRIEF.md
# Watchdog Timer with Reset Status

This block is a watchdog timer. A 12-bit free-running prescaler divides the system clock, and a 3-bit clock select picks one of eight taps from it. Each selected tap pulse advances an 8-bit up-counter. In watchdog mode the counter must be reloaded before it passes 255. If it is not, the block holds the internal chip reset low for a fixed 518 system clocks. If the reset-output-enable bit is set, it also drives the external reset pin low for the same cycles. In interval mode the counter wraps silently.

A status register tells software whether the last reset came from the watchdog. Its flag can only be cleared by software. The flag and the reset-output-enable bit both survive the watchdog's own reset, and both are cleared by a reset arriving on the external pin.

Every register write carries a key in the upper byte of a 16-bit write word and is dropped unless the key matches. The status register is written at one address and read at the next. The external reset input acts asynchronously and is released through a two-stage synchroniser. Loopback of the driven pin onto the reset input belongs to the pad and is not modelled here.

Top module: `wdt_rststat`

## Requirements
- R1: After the external reset input is released, the control register reads 0x98, the counter reads 0x00 and the status register reads 0x3F. The internal reset output is high and the pin drive is low.
- R2: With the count-enable bit (control bit 5) set, the counter advances by one every N system clocks. N is set by the clock select (control bits 2:0): 0→2, 1→32, 2→64, 3→128, 4→256, 5→512, 6→2048, 7→4096.
- R3: In watchdog mode (control bit 6 = 1), a count step from 255 drives the internal reset output low from the next cycle for exactly 518 cycles.
- R4: The watchdog flag (status bit 7) is set by a watchdog-mode overflow. An overflow in interval mode (control bit 6 = 0) only wraps the counter to 0, with no reset and no flag.
- R5: While the internal reset is low, the pin drive output is high if and only if the reset-output-enable bit (status bit 6) is 1.
- R6: A watchdog reset returns the control register to 0x98 and the counter to 0, keeps the flag and the enable bit, and ignores all writes while it lasts.
- R7: A status write with bit 7 = 0 clears the flag. Bit 7 = 1 leaves it unchanged, so software cannot set the flag. Bit 6 loads the enable bit.
- R8: The external reset input clears both the flag and the enable bit.
- R9: A write whose upper byte is not 0x5A changes no register.
- R10: The status register is written at address 0x14 and read at 0x15, with bits 5:0 reading as 1. Address 0x14 reads 0xFF, and writes to 0x15 have no effect.
- R11: A keyed write at address 0x12 loads the counter from the low data byte, and the counter reads back at 0x11. This load takes priority over a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | External reset pin level, active low, asynchronous |
| bus_addr | input | 8 | Register address (low byte) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write word; upper byte is the key, lower byte the data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| rst_int_n | output | 1 | Internal chip reset, active low |
| rst_drv | output | 1 | Request to pull the reset pin low |

## Verification
The assertions assume that the reset pin input is not tied back to the block's own pin drive. They also assume that bus_addr, bus_wr and bus_wdata change only away from the rising clock edge. The stimulus drives every input on the falling edge and keeps rst_pin_n separate from rst_drv. As a result, the 518-cycle window, the flag rise and the default control values during the pulse are all seen exactly as the block produces them. Long overflow waits are shortened by preloading the counter near 255 rather than counting from zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ADDR_CTRL    = 8'h10;
  localparam logic [7:0] ADDR_CNT_RD  = 8'h11;
  localparam logic [7:0] ADDR_CNT_WR  = 8'h12;
  localparam logic [7:0] ADDR_STAT_WR = 8'h14;
  localparam logic [7:0] ADDR_STAT_RD = 8'h15;

  typedef struct packed {
    logic       mode;   // 1 = watchdog, 0 = interval
    logic       run;    // count enable
    logic [2:0] cks;    // tap select
  } ctrl_t;

  // number of prescaler bits that must be all ones for a tap pulse
  function automatic int unsigned tap_bits(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 5;
      3'd2:    return 6;
      3'd3:    return 7;
      3'd4:    return 8;
      3'd5:    return 9;
      3'd6:    return 11;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] sel,
  output logic       tick
);
  localparam int NTAPS = 8;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] tap_mask [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign tap_mask[g] = PRE_W'((64'd1 << wdt_pkg::tap_bits(3'(g))) - 64'd1);
  end

  always_comb begin
    pre_d = clr ? '0 : pre_q + 1'b1;
    tick  = ((pre_q & tap_mask[sel]) == tap_mask[sel]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_count_unit.sv
module wdt_count_unit #(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick,
  input  logic               wr_ctrl,
  input  logic               wr_cnt,
  input  logic [7:0]         wdata,
  output wdt_pkg::ctrl_t     ctrl_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               wd_ovf
);
  wdt_pkg::ctrl_t   ctrl_d;
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  always_comb begin
    step   = ctrl_q.run && tick;
    wd_ovf = !clr && !wr_cnt && step && ctrl_q.mode && (&cnt_q);
    ctrl_d = ctrl_q;
    cnt_d  = cnt_q;
    if (clr) begin
      ctrl_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_ctrl) ctrl_d = '{mode: wdata[6], run: wdata[5], cks: wdata[2:0]};
      if (wr_cnt)    cnt_d = wdata[CNT_W-1:0];
      else if (step) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/wdt_reset_unit.sv
module wdt_reset_unit #(
  parameter int PULSE_LEN = 518
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_ovf,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  output logic       pulse_q,
  output logic       flag_q,
  output logic       oe_q
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);

  logic [PW-1:0] pw_q, pw_d;
  logic          pulse_d, flag_d, oe_d;

  always_comb begin
    pw_d    = pw_q;
    pulse_d = pulse_q;
    if (pulse_q) begin
      pw_d = pw_q + 1'b1;
      if (pw_q == LAST) pulse_d = 1'b0;
    end else if (wd_ovf) begin
      pulse_d = 1'b1;
      pw_d    = '0;
    end
    if (wd_ovf)                   flag_d = 1'b1;
    else if (wr_stat && !wdata[7]) flag_d = 1'b0;
    else                          flag_d = flag_q;
    oe_d = wr_stat ? wdata[6] : oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q    <= '0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      pw_q    <= pw_d;
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
      oe_q    <= oe_d;
    end
  end
endmodule

// File: rtl/wdt_rststat.sv
module wdt_rststat #(
  parameter int          CNT_W     = 8,
  parameter int          PRE_W     = 12,
  parameter int          PULSE_LEN = 518,
  parameter logic [7:0]  KEY       = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_pin_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        rst_int_n,
  output logic        rst_drv
);
  import wdt_pkg::*;

  logic             sync1_q, rst_sync_n;
  logic             pulse_q, flag_q, oe_q, tick, wd_ovf;
  logic             wr_ok;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      sync1_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      sync1_q    <= 1'b1;
      rst_sync_n <= sync1_q;
    end
  end

  assign wr_ok = bus_wr && (bus_wdata[15:8] == KEY) && !pulse_q;

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .clr(pulse_q), .sel(ctrl_q.cks), .tick(tick)
  );

  wdt_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(pulse_q), .tick(tick),
    .wr_ctrl(wr_ok && bus_addr == ADDR_CTRL),
    .wr_cnt(wr_ok && bus_addr == ADDR_CNT_WR),
    .wdata(bus_wdata[7:0]), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .wd_ovf(wd_ovf)
  );

  wdt_reset_unit #(.PULSE_LEN(PULSE_LEN)) u_rst (
    .clk(clk), .rst_n(rst_sync_n), .wd_ovf(wd_ovf),
    .wr_stat(wr_ok && bus_addr == ADDR_STAT_WR),
    .wdata(bus_wdata[7:0]), .pulse_q(pulse_q), .flag_q(flag_q), .oe_q(oe_q)
  );

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:    bus_rdata = {1'b1, ctrl_q.mode, ctrl_q.run, 2'b11, ctrl_q.cks};
      ADDR_CNT_RD:  bus_rdata = 8'(cnt_q);
      ADDR_STAT_RD: bus_rdata = {flag_q, oe_q, 6'h3F};
      default:      bus_rdata = 8'hFF;
    endcase
  end

  assign rst_int_n = !pulse_q;
  assign rst_drv   = pulse_q && oe_q;
endmodule

// File: rtl/wdt_rststat_sva.sv
module wdt_rststat_sva #(
  parameter int PULSE_LEN = 518
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_int_n,
  input logic       rst_drv,
  input logic       flag,
  input logic       oe,
  input logic [4:0] ctrl,
  input logic [7:0] cnt,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_rdata
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= '0;
    else if (!rst_int_n) low_cnt <= low_cnt + 1'b1;
    else                 low_cnt <= '0;
  end

  // R3: pulse lasts exactly PULSE_LEN cycles
  a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_int_n)) |-> (low_cnt == 16'(PULSE_LEN)));
  a_r3_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_int_n) |-> (low_cnt < 16'(PULSE_LEN)));
  // R4: flag only rises together with a watchdog reset
  a_r4_flag_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $fell(rst_int_n));
  // R5: pin drive only inside the internal reset, and only when enabled
  a_r5_drv_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_drv |-> (!rst_int_n && oe));
  a_r5_drv_when_en: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_int_n && oe) |-> rst_drv);
  // R6: defaults during pulse, status kept
  a_r6_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_int_n && $past(!rst_int_n)) |-> (ctrl == 5'd0 && cnt == 8'd0));
  a_r6_oe_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_int_n) |=> $stable(oe));
  // R10: low status bits read as one
  a_r10_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h15) |-> (bus_rdata[5:0] == 6'h3F));
endmodule

bind wdt_rststat wdt_rststat_sva #(.PULSE_LEN(PULSE_LEN)) u_sva (
  .clk(clk), .rst_n(rst_sync_n), .rst_int_n(rst_int_n), .rst_drv(rst_drv),
  .flag(flag_q), .oe(oe_q), .ctrl(ctrl_q), .cnt(8'(cnt_q)),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/wdt_rststat_bench.sv
module wdt_rststat_bench;
  logic        clk = 1'b0;
  logic        rst_pin_n = 1'b0;
  logic [7:0]  bus_addr = 8'h10;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [7:0]  bus_rdata;
  logic        rst_int_n, rst_drv;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  wdt_rststat u_wdt_rststat (
    .clk(clk), .rst_pin_n(rst_pin_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_int_n(rst_int_n), .rst_drv(rst_drv)
  );

  // ---------------- reference model ----------------
  int m_presc = 0, m_cnt = 0, m_cks = 0, m_pl = 0, m_stage = 0;
  bit m_mode = 0, m_run = 0, m_flag = 0, m_oe = 0;

  function automatic int divisor(int s);
    case (s)
      0: return 2;    1: return 32;   2: return 64;   3: return 128;
      4: return 256;  5: return 512;  6: return 2048; default: return 4096;
    endcase
  endfunction

  task automatic m_clear_timer();
    m_presc = 0; m_cnt = 0; m_cks = 0; m_mode = 0; m_run = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_pin_n) begin
      m_clear_timer(); m_flag = 0; m_oe = 0; m_pl = 0; m_stage = 0;
    end else if (m_stage < 2) begin
      m_clear_timer(); m_flag = 0; m_oe = 0; m_pl = 0; m_stage++;
    end else if (m_pl > 0) begin
      m_clear_timer(); m_pl--;
    end else begin
      bit okw, tick, ovf;
      int d;
      okw  = bus_wr && (bus_wdata[15:8] == 8'h5A);
      d    = divisor(m_cks);
      tick = (m_presc % d) == d - 1;
      m_presc = (m_presc + 1) % 4096;
      ovf = 0;
      if (okw && bus_addr == 8'h12) m_cnt = bus_wdata[7:0];
      else if (m_run && tick) begin
        if (m_cnt == 255) begin m_cnt = 0; ovf = m_mode; end
        else m_cnt++;
      end
      if (okw && bus_addr == 8'h10) begin
        m_mode = bus_wdata[6]; m_run = bus_wdata[5]; m_cks = bus_wdata[2:0];
      end
      if (okw && bus_addr == 8'h14) begin
        if (!bus_wdata[7]) m_flag = 0;
        m_oe = bus_wdata[6];
      end
      if (ovf) begin m_flag = 1; m_pl = 518; end
    end
  end

  function automatic logic [7:0] m_read(logic [7:0] a);
    case (a)
      8'h10:   return {1'b1, m_mode, m_run, 2'b11, 3'(m_cks)};
      8'h11:   return 8'(m_cnt);
      8'h15:   return {m_flag, m_oe, 6'h3F};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R2 R3 R5 R6)
  always @(posedge clk) begin
    #2;
    check(bus_rdata == m_read(bus_addr), "R2 R6 model read", bus_rdata, m_read(bus_addr));
    check(rst_int_n == (m_pl == 0), "R3 model rst_int_n", rst_int_n, m_pl == 0);
    check(rst_drv == (m_pl > 0 && m_oe), "R5 model rst_drv", rst_drv, m_pl > 0 && m_oe);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a;
    @(posedge clk); #2; v = bus_rdata;
  endtask

  task automatic pin_reset();
    @(negedge clk); rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic measure_pulse(output int low, output int drv);
    int guard = 0;
    low = 0; drv = 0;
    while (rst_int_n && guard < 3000) begin @(posedge clk); #2; guard++; end
    while (!rst_int_n && low < 3000) begin
      low++; if (rst_drv) drv++;
      @(posedge clk); #2;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int low, drv;
    bit saw_low;

    pin_reset();
    rd(8'h10, v); check(v == 8'h98, "R1 ctrl", v, 8'h98);
    rd(8'h11, v); check(v == 8'h00, "R1 cnt", v, 8'h00);
    rd(8'h15, v); check(v == 8'h3F, "R1 status", v, 8'h3F);
    check(rst_int_n == 1'b1 && rst_drv == 1'b0, "R1 outputs", {rst_int_n, rst_drv}, 2'b10);

    // R9 wrong key
    wr(8'h10, 16'hA560); rd(8'h10, v); check(v == 8'h98, "R9 ctrl wrong key", v, 8'h98);
    wr(8'h12, 16'h0077); rd(8'h11, v); check(v == 8'h00, "R9 cnt wrong key", v, 8'h00);
    wr(8'h14, 16'h1240); rd(8'h15, v); check(v == 8'h3F, "R9 status wrong key", v, 8'h3F);

    // R11 counter load
    wr(8'h12, 16'h5A40); rd(8'h11, v); check(v == 8'h40, "R11 cnt load", v, 8'h40);

    // R2 every tap
    for (int s = 0; s < 8; s++) begin
      wr(8'h12, 16'h5A10);
      wr(8'h10, 16'h5A20 | 16'(s));
      repeat (3 * divisor(s)) @(negedge clk);
      rd(8'h11, v);
      check(v >= 8'h12 && v <= 8'h14, "R2 tap rate", v, 8'h13);
      wr(8'h10, 16'h5A00);
    end

    // R4 interval-mode wrap
    wr(8'h12, 16'h5AFE);
    wr(8'h10, 16'h5A20);
    saw_low = 0;
    for (int i = 0; i < 12; i++) begin @(posedge clk); #2; if (!rst_int_n) saw_low = 1; end
    check(!saw_low, "R4 no reset in interval mode", saw_low, 0);
    rd(8'h11, v); check(v < 8'h10, "R4 counter wrapped", v, 8'h05);
    rd(8'h15, v); check(v == 8'h3F, "R4 no flag in interval mode", v, 8'h3F);
    wr(8'h10, 16'h5A00);

    // R3 R5 watchdog overflow, pin drive disabled
    wr(8'h14, 16'h5A00);
    wr(8'h12, 16'h5AF0);
    wr(8'h10, 16'h5A60);
    measure_pulse(low, drv);
    check(low == 518, "R3 pulse length", low, 518);
    check(drv == 0, "R5 no drive when disabled", drv, 0);
    rd(8'h15, v); check(v == 8'hBF, "R4 flag set", v, 8'hBF);
    rd(8'h10, v); check(v == 8'h98, "R6 ctrl default", v, 8'h98);
    rd(8'h11, v); check(v == 8'h00, "R6 cnt default", v, 8'h00);

    // R7 flag clear-only
    wr(8'h14, 16'h5AC0); rd(8'h15, v); check(v == 8'hFF, "R7 write 1 keeps flag", v, 8'hFF);
    wr(8'h14, 16'h5A40); rd(8'h15, v); check(v == 8'h7F, "R7 write 0 clears", v, 8'h7F);
    wr(8'h14, 16'h5AC0); rd(8'h15, v); check(v == 8'h7F, "R7 cannot set", v, 8'h7F);

    // R5 R6 overflow with pin drive
    wr(8'h12, 16'h5AFA);
    wr(8'h10, 16'h5A60);
    measure_pulse(low, drv);
    check(low == 518, "R3 second pulse length", low, 518);
    check(drv == 518, "R5 drive follows pulse", drv, 518);
    rd(8'h15, v); check(v == 8'hFF, "R6 status kept", v, 8'hFF);

    // R10 address split
    rd(8'h14, v); check(v == 8'hFF, "R10 write address reads FF", v, 8'hFF);
    wr(8'h15, 16'h5A00); rd(8'h15, v); check(v == 8'hFF, "R10 write to read address", v, 8'hFF);

    // R8 pin reset
    pin_reset();
    rd(8'h15, v); check(v == 8'h3F, "R8 pin reset clears", v, 8'h3F);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule